// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits next to a shared two-port word memory and turns ordinary accesses to the two topmost word addresses into a doorbell between the ports. The left port posts a message by writing the highest address. This raises the right port's interrupt. The right port posts by writing the address one below the top. This raises the left port's interrupt. Each receiver acknowledges by reading the word that was written to it, and that read lowers its own interrupt. No separate control registers exist: the flags change only as side effects of memory accesses.

Both ports are sampled on one clock. An access is taken to be a write when chip enable is low and read/write is low. It is taken to be a read when chip enable is low, read/write is high and output enable is low. Reset is asynchronous on assertion and is released through a two-stage synchronizer. The address width is a parameter, so the mailbox words move with the array size: 0xFFF/0xFFE for 12 bits, 0x1FFF/0x1FFE for 13 bits, and 0x3FFF/0x3FFE for 14 bits.

Top module: `mbx_irq`

## Requirements
- R1: While reset is active, and after it is released, both interrupt outputs are high, which is the deasserted state.
- R2: A left-port write (l_ce_n=0, l_rw=0) to address all-ones drives r_irq_n low one clock later.
- R3: A right-port write (r_ce_n=0, r_rw=0) to address all-ones minus one drives l_irq_n low one clock later.
- R4: A right-port read (r_ce_n=0, r_rw=1, r_oe_n=0) of address all-ones returns r_irq_n high one clock later.
- R5: A left-port read (l_ce_n=0, l_rw=1, l_oe_n=0) of address all-ones minus one returns l_irq_n high one clock later.
- R6: A read with output enable high does not clear an interrupt.
- R7: When the setting write and the clearing read of the same interrupt fall in the same cycle, the interrupt ends up asserted.
- R8: An interrupt holds its value when no setting or clearing access occurs. This covers accesses to other addresses, accesses with chip enable high, a port writing its own receive word, and a port reading the other port's receive word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_addr | input | AW | Left port word address |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw | input | 1 | Left read/write: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| r_addr | input | AW | Right port word address |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw | input | 1 | Right read/write: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| l_irq_n | output | 1 | Interrupt to the left port, active low |
| r_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
The two functions that can meet in one cycle are the posting write and the acknowledging read of the same mailbox word. They come from opposite ports, so they can overlap freely. The bench provokes this by driving, in a single cycle, a left write of the top word together with a right read of the same word, and likewise for the lower word. It then expects the interrupt to remain asserted, following the priority given to the set. A reference model in the bench computes every flag state as set OR (old AND NOT clear) and compares it against the outputs after each edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_e;

  // Decode the strobes of one port into the kind of access it makes.
  function automatic acc_e classify(input logic ce_n, input logic rw, input logic oe_n);
    acc_e k;
    k = ACC_NONE;
    if (!ce_n) begin
      if (!rw)        k = ACC_WRITE;
      else if (!oe_n) k = ACC_READ;
    end
    return k;
  endfunction

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_q_n = stage_q[1];
endmodule

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
  parameter int             AW      = 13,
  parameter logic [AW-1:0]  WR_ADDR = '1,
  parameter logic [AW-1:0]  RD_ADDR = '0
) (
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          rw,
  input  logic          oe_n,
  output logic          wr_hit,
  output logic          rd_hit
);
  import mbx_pkg::*;

  acc_e kind;

  always_comb begin
    kind   = classify(ce_n, rw, oe_n);
    wr_hit = (kind == ACC_WRITE) && (addr == WR_ADDR);
    rd_hit = (kind == ACC_READ)  && (addr == RD_ADDR);
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_n
);
  logic pend_q;
  logic pend_d;
  logic upd;

  // Set outranks clear when both arrive together.
  always_comb begin
    upd    = set | clr;
    pend_d = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (upd) pend_q <= pend_d;
  end

  assign flag_n = ~pend_q;
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] l_addr,
  input  logic          l_ce_n,
  input  logic          l_rw,
  input  logic          l_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic          r_ce_n,
  input  logic          r_rw,
  input  logic          r_oe_n,
  output logic          l_irq_n,
  output logic          r_irq_n
);
  localparam logic [AW-1:0] TOP_WORD  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT_WORD = {{(AW-1){1'b1}}, 1'b0};
  localparam int            NPORT     = 2;

  logic                rst_q_n;
  logic [AW-1:0]       addr_v [NPORT];
  logic [NPORT-1:0]    ce_v, rw_v, oe_v;
  logic [NPORT-1:0]    wr_hit, rd_hit, irq_v;

  mbx_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  always_comb begin
    addr_v[0] = l_addr; ce_v[0] = l_ce_n; rw_v[0] = l_rw; oe_v[0] = l_oe_n;
    addr_v[1] = r_addr; ce_v[1] = r_ce_n; rw_v[1] = r_rw; oe_v[1] = r_oe_n;
  end

  // Port 0 (left) sends through the top word, port 1 (right) through the next.
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int            PEER = NPORT - 1 - p;
    localparam logic [AW-1:0] TX   = (p == 0) ? TOP_WORD : NEXT_WORD;
    localparam logic [AW-1:0] RX   = (p == 0) ? NEXT_WORD : TOP_WORD;

    mbx_port_dec #(.AW(AW), .WR_ADDR(TX), .RD_ADDR(RX)) u_dec (
      .addr  (addr_v[p]),
      .ce_n  (ce_v[p]),
      .rw    (rw_v[p]),
      .oe_n  (oe_v[p]),
      .wr_hit(wr_hit[p]),
      .rd_hit(rd_hit[p])
    );

    mbx_flag u_flag (
      .clk   (clk),
      .rst_n (rst_q_n),
      .set   (wr_hit[PEER]),
      .clr   (rd_hit[p]),
      .flag_n(irq_v[p])
    );
  end

  assign l_irq_n = irq_v[0];
  assign r_irq_n = irq_v[1];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic [AW-1:0] l_addr,
  input logic          l_ce_n,
  input logic          l_rw,
  input logic          l_oe_n,
  input logic [AW-1:0] r_addr,
  input logic          r_ce_n,
  input logic          r_rw,
  input logic          r_oe_n,
  input logic          l_irq_n,
  input logic          r_irq_n
);
  localparam logic [AW-1:0] TOPW = {AW{1'b1}};
  localparam logic [AW-1:0] NXTW = {{(AW-1){1'b1}}, 1'b0};

  logic l_post, r_post, l_ack, r_ack;
  assign l_post = !l_ce_n && !l_rw && (l_addr == TOPW);
  assign r_post = !r_ce_n && !r_rw && (r_addr == NXTW);
  assign l_ack  = !l_ce_n && l_rw && !l_oe_n && (l_addr == NXTW);
  assign r_ack  = !r_ce_n && r_rw && !r_oe_n && (r_addr == TOPW);

  always @(posedge clk) begin
    if (!rst_q_n) begin
      AST_RESET_IDLE: assert (l_irq_n && r_irq_n); // R1
    end
  end

  AST_LEFT_POST: assert property (@(posedge clk) disable iff (!rst_q_n) l_post |=> !r_irq_n); // R2
  AST_RIGHT_POST: assert property (@(posedge clk) disable iff (!rst_q_n) r_post |=> !l_irq_n); // R3
  AST_RIGHT_ACK: assert property (@(posedge clk) disable iff (!rst_q_n) (r_ack && !l_post) |=> r_irq_n); // R4
  AST_LEFT_ACK: assert property (@(posedge clk) disable iff (!rst_q_n) (l_ack && !r_post) |=> l_irq_n); // R5
  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n) (!l_post && !r_ack) |=> $stable(r_irq_n)); // R8
  AST_L_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n) (!r_post && !l_ack) |=> $stable(l_irq_n)); // R8
endmodule

bind mbx_irq mbx_irq_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_q_n(rst_q_n),
  .l_addr(l_addr), .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n),
  .r_addr(r_addr), .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n),
  .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
);

// File: tb/test_mbx_irq.sv
module test_mbx_irq;
  localparam int AW = 13;
  localparam logic [AW-1:0] TOPW = {AW{1'b1}};
  localparam logic [AW-1:0] NXTW = {{(AW-1){1'b1}}, 1'b0};

  typedef enum int {OP_IDLE, OP_WR, OP_RD, OP_RD_NOOE, OP_WR_NOCE} op_e;
  typedef struct { logic l_n; logic r_n; string tag; } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_ce_n, l_rw, l_oe_n, r_ce_n, r_rw, r_oe_n;
  logic l_irq_n, r_irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic ml, mr; // model: 1 = interrupt pending
  exp_t sb[$];

  always #2.5 clk = ~clk;

  mbx_irq #(.AW(AW)) i_mbx_irq (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n),
    .r_addr(r_addr), .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  task automatic drive_port(input op_e op, output logic ce, output logic rw, output logic oe);
    ce = 1'b1; rw = 1'b1; oe = 1'b1;
    case (op)
      OP_WR:      begin ce = 1'b0; rw = 1'b0; end
      OP_RD:      begin ce = 1'b0; oe = 1'b0; end
      OP_RD_NOOE: begin ce = 1'b0; end
      OP_WR_NOCE: begin rw = 1'b0; end
      default: ;
    endcase
  endtask

  // Driver: applies one cycle of stimulus and queues the expected flags.
  task automatic cycle(input op_e lop, input logic [AW-1:0] la,
                       input op_e rop, input logic [AW-1:0] ra, input string tag);
    logic ls, lc, rs, rc;
    exp_t e;
    @(negedge clk);
    l_addr = la; r_addr = ra;
    drive_port(lop, l_ce_n, l_rw, l_oe_n);
    drive_port(rop, r_ce_n, r_rw, r_oe_n);
    rs = (lop == OP_WR) && (la == TOPW);
    ls = (rop == OP_WR) && (ra == NXTW);
    lc = (lop == OP_RD) && (la == NXTW);
    rc = (rop == OP_RD) && (ra == TOPW);
    ml = ls | (ml & ~lc);
    mr = rs | (mr & ~rc);
    e.l_n = ~ml; e.r_n = ~mr; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares after each edge once the design has updated.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (l_irq_n !== e.l_n || r_irq_n !== e.r_n) begin
        errors++;
        $display("FAIL %s: l_irq_n/r_irq_n got %b%b expected %b%b", e.tag, l_irq_n, r_irq_n, e.l_n, e.r_n);
      end
    end
  end

  initial begin
    rst_n = 1'b0; ml = 1'b0; mr = 1'b0;
    l_addr = '0; r_addr = '0;
    l_ce_n = 1'b1; l_rw = 1'b1; l_oe_n = 1'b1;
    r_ce_n = 1'b1; r_rw = 1'b1; r_oe_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (l_irq_n !== 1'b1 || r_irq_n !== 1'b1) begin
      errors++;
      $display("FAIL R1: during reset got %b%b expected 11", l_irq_n, r_irq_n);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cycle(OP_IDLE, '0, OP_IDLE, '0, "R1");
    cycle(OP_WR, TOPW, OP_IDLE, '0, "R2");
    cycle(OP_IDLE, '0, OP_RD_NOOE, TOPW, "R6");
    cycle(OP_RD, TOPW, OP_WR, TOPW, "R8");
    cycle(OP_IDLE, '0, OP_RD, TOPW, "R4");
    cycle(OP_IDLE, '0, OP_WR, NXTW, "R3");
    cycle(OP_RD_NOOE, NXTW, OP_IDLE, '0, "R6");
    cycle(OP_RD, NXTW, OP_IDLE, '0, "R5");
    cycle(OP_WR, TOPW, OP_RD, TOPW, "R7");
    cycle(OP_IDLE, '0, OP_IDLE, '0, "R8");
    cycle(OP_RD, NXTW, OP_WR, NXTW, "R7");
    cycle(OP_WR, NXTW, OP_RD, NXTW, "R8");
    cycle(OP_RD, NXTW, OP_RD, TOPW, "R4");
    cycle(OP_WR, TOPW - 2, OP_WR, '0, "R8");
    cycle(OP_WR_NOCE, TOPW, OP_WR_NOCE, NXTW, "R8");
    cycle(OP_WR, TOPW, OP_WR, NXTW, "R2");
    cycle(OP_WR, NXTW, OP_RD, NXTW, "R8");
    cycle(OP_RD, NXTW, OP_RD, TOPW, "R5");
    cycle(OP_IDLE, '0, OP_IDLE, '0, "R8");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule